// File: doc/BRIEF.md
# Ripple-Carry Adder-Subtractor with Signed Overflow

This block adds or subtracts two N-bit words in a single combinational path. One carry chain serves both operations. Each stage of the chain is a 1-bit full adder built from two half adders whose carries are ORed together. Each stage passes its carry to the next stage up, starting at bit 0 and ending at the top bit. When subtract is selected, every bit of the second operand is inverted and the bottom carry is forced to one. The chain then computes A + ~B + 1, which is the two's complement difference.

There are three outputs. The carry-out is an unsigned carry when adding. When subtracting it means "no borrow", so it is 1 when A >= B. The overflow flag is for signed operands. It is the XOR of the carry entering the most significant stage and the carry leaving it. A parameter chooses whether the external carry-in port takes part in additions. The width has a minimum of 2 and is checked when the design is elaborated. The block has no clock and no state. Its worst-case delay is about two gate levels per bit, because a carry can ripple the full length of the chain.

Top module: `rca_addsub`

## Requirements
- R1: With `sub_en`=0 and `USE_CIN`=1, the concatenation {`cout`,`sum_out`} equals the unsigned sum `a_in` + `b_in` + `cin`.
- R2: With `sub_en`=1, `sum_out` equals (`a_in` - `b_in`) mod 2^N, and `cout` is 1 exactly when `a_in` >= `b_in` as unsigned numbers.
- R3: With `sub_en`=1, the value of `cin` has no effect on any output.
- R4: `ovf_out` is 1 exactly when the true signed result lies outside [-2^(N-1), 2^(N-1)-1]. The operands are read as two's complement, and the true result is `a_in`+`b_in`+carry-in when adding and `a_in`-`b_in` when subtracting.
- R5: A carry ripples across every stage. Adding all-ones + 0 + carry-in 1 gives `sum_out`=0, `cout`=1 and `ovf_out`=0. Subtracting 0 - 0 gives `sum_out`=0, `cout`=1 and `ovf_out`=0.
- R6: With `USE_CIN`=0, `cin` is ignored when adding, and {`cout`,`sum_out`} equals `a_in` + `b_in`.
- R7: With every input at 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand (minuend when subtracting) |
| b_in | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 0 selects add, 1 selects subtract |
| cin | input | 1 | Carry-in for additions; used only when USE_CIN=1 |
| sum_out | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top stage (no-borrow when subtracting) |
| ovf_out | output | 1 | Two's complement overflow |

## Verification
Two results come out of the same evaluation: the unsigned carry-out and the signed overflow. Both depend on the carries around the top stage, so a single input vector can set either one, both, or neither.

At a width of 4, every combination of operands, mode and carry-in is applied. This covers all four pairings, for example 7+1 (overflow without carry) and -8+-8 (both). Each vector is judged against a reference. The reference computes the unsigned carry and the signed range test separately from each other.

At a width of 16, random vectors and directed edge values repeat the same judgement.

// File: rtl/rca_pkg.sv
package rca_pkg;
   localparam int unsigned RCA_MIN_WIDTH = 2;

   typedef enum logic {
      RCA_OP_ADD = 1'b0,
      RCA_OP_SUB = 1'b1
   } rca_op_e;
endpackage

// File: rtl/rca_half_add.sv
module rca_half_add (
   input  logic x_i,
   input  logic y_i,
   output logic s_o,
   output logic c_o
);
   assign s_o = x_i ^ y_i;
   assign c_o = x_i & y_i;
endmodule

// File: rtl/rca_full_add.sv
module rca_full_add (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic s_first;
   logic c_first;
   logic c_second;

   rca_half_add u_ha_lo (
      .x_i (x_i),
      .y_i (y_i),
      .s_o (s_first),
      .c_o (c_first)
   );

   rca_half_add u_ha_hi (
      .x_i (s_first),
      .y_i (c_i),
      .s_o (s_o),
      .c_o (c_second)
   );

   assign c_o = c_first | c_second;

   // R1
   always_comb begin
      fa_count_chk : assert ({c_o, s_o} == (2'(x_i) + 2'(y_i) + 2'(c_i)))
         else $error("full adder stage disagrees with bit count");
   end
endmodule

// File: rtl/rca_chain.sv
module rca_chain #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             c0_i,
   output logic [WIDTH-1:0] s_o,
   output logic [WIDTH:0]   carry_o
);
   assign carry_o[0] = c0_i;

   for (genvar k = 0; k < WIDTH; k++) begin : g_stage
      rca_full_add u_fa (
         .x_i (x_i[k]),
         .y_i (y_i[k]),
         .c_i (carry_o[k]),
         .s_o (s_o[k]),
         .c_o (carry_o[k+1])
      );
   end
endmodule

// File: rtl/rca_addsub.sv
module rca_addsub
   import rca_pkg::*;
#(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned USE_CIN = 1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             sub_en,
   input  logic             cin,
   output logic [WIDTH-1:0] sum_out,
   output logic             cout,
   output logic             ovf_out
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < RCA_MIN_WIDTH) begin : g_bad_width
      $error("rca_addsub: WIDTH must be at least 2");
   end
   if (USE_CIN > 1) begin : g_bad_cin
      $error("rca_addsub: USE_CIN must be 0 or 1");
   end

   rca_op_e          op;
   logic [WIDTH-1:0] b_cond;
   logic             ext_cin;
   logic             c_first;
   logic [WIDTH:0]   carries;

   assign op = rca_op_e'(sub_en);

   for (genvar k = 0; k < WIDTH; k++) begin : g_binv
      assign b_cond[k] = b_in[k] ^ sub_en;
   end

   if (USE_CIN == 1) begin : g_cin_on
      assign ext_cin = cin;
   end else begin : g_cin_off
      logic unused_cin;
      assign unused_cin = cin;
      assign ext_cin    = 1'b0;
   end

   assign c_first = (op == RCA_OP_SUB) ? 1'b1 : ext_cin;

   rca_chain #(.WIDTH(WIDTH)) u_chain (
      .x_i     (a_in),
      .y_i     (b_cond),
      .c0_i    (c_first),
      .s_o     (sum_out),
      .carry_o (carries)
   );

   assign cout    = carries[WIDTH];
   assign ovf_out = carries[WIDTH] ^ carries[MSB];

   logic [WIDTH:0] ref_add;
   logic [WIDTH:0] ref_sub;
   always_comb begin
      ref_add = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, ext_cin};
      ref_sub = {1'b0, a_in} + {1'b0, ~b_in} + {{WIDTH{1'b0}}, 1'b1};
      // R1
      if (!sub_en) begin
         add_result_chk : assert ({cout, sum_out} == ref_add)
            else $error("add result mismatch");
      end
      // R2
      if (sub_en) begin
         sub_result_chk : assert ((sum_out == (a_in - b_in)) && (cout == (a_in >= b_in)))
            else $error("subtract result mismatch");
      end
      // R4
      ovf_sign_chk : assert (ovf_out ==
            ((a_in[MSB] == b_cond[MSB]) && (sum_out[MSB] != a_in[MSB])))
         else $error("overflow disagrees with sign rule");
   end
endmodule

// File: tb/sim_rca_addsub.sv
module sim_rca_addsub;
   localparam int CLK_PERIOD = 10;
   localparam int WN = 4;
   localparam int WW = 16;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [WN-1:0] a4 = '0, b4 = '0;
   logic [WW-1:0] a16 = '0, b16 = '0;
   logic sub = 1'b0, ci = 1'b0;

   logic [WN-1:0] s0, s1;
   logic [WW-1:0] s2;
   logic c0, c1, c2, o0, o1, o2;

   rca_addsub #(.WIDTH(WN), .USE_CIN(1)) u0 (
      .a_in(a4), .b_in(b4), .sub_en(sub), .cin(ci),
      .sum_out(s0), .cout(c0), .ovf_out(o0));
   rca_addsub #(.WIDTH(WN), .USE_CIN(0)) u1 (
      .a_in(a4), .b_in(b4), .sub_en(sub), .cin(ci),
      .sum_out(s1), .cout(c1), .ovf_out(o1));
   rca_addsub #(.WIDTH(WW), .USE_CIN(1)) u2 (
      .a_in(a16), .b_in(b16), .sub_en(sub), .cin(ci),
      .sum_out(s2), .cout(c2), .ovf_out(o2));

   // Reference: unsigned carry and signed range test computed separately.
   task automatic judge(input int w, input longint a, input longint b,
                        input bit sb, input bit cb, input bit has,
                        input longint gs, input bit gc, input bit go,
                        input string tag);
      longint mask, bb, cc, t, es, sa, sbv, r;
      bit ec, eo;
      mask = (longint'(1) << w) - 1;
      bb   = sb ? (~b & mask) : b;
      cc   = sb ? 1 : (has ? longint'(cb) : 0);
      t    = a + bb + cc;
      es   = t & mask;
      ec   = ((t >> w) & 1) != 0;
      sa   = ((a >> (w-1)) & 1) != 0 ? a - (longint'(1) << w) : a;
      sbv  = ((b >> (w-1)) & 1) != 0 ? b - (longint'(1) << w) : b;
      r    = sb ? sa - sbv : sa + sbv + cc;
      eo   = (r > (longint'(1) << (w-1)) - 1) || (r < -(longint'(1) << (w-1)));
      checks++;
      if (gs != es || gc != ec || go != eo) begin
         errors++;
         $display("FAIL %s w=%0d a=%0h b=%0h sub=%0b cin=%0b actual s=%0h c=%0b o=%0b expected s=%0h c=%0b o=%0b",
                  tag, w, a, b, sb, cb, gs, gc, go, es, ec, eo);
      end
   endtask

   task automatic drive(input longint a, input longint b, input bit sb, input bit cb);
      @(posedge clk);
      #1;
      a4 = a[WN-1:0]; b4 = b[WN-1:0];
      a16 = a[WW-1:0]; b16 = b[WW-1:0];
      sub = sb; ci = cb;
      @(negedge clk);
   endtask

   task automatic wide(input longint a, input longint b, input bit sb, input bit cb, input string tag);
      drive(a, b, sb, cb);
      judge(WW, a, b, sb, cb, 1'b1, longint'(s2), c2, o2, tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R7: all-zero inputs
      drive(0, 0, 1'b0, 1'b0);
      checks++;
      if (s0 != 0 || c0 || o0 || s2 != 0 || c2 || o2) begin
         errors++;
         $display("FAIL R7 actual s=%0h c=%0b o=%0b expected 0 0 0", s0, c0, o0);
      end
      // Exhaustive narrow sweep: R1 R2 R3 R4 R6
      for (int sb = 0; sb < 2; sb++)
         for (int cb = 0; cb < 2; cb++)
            for (int a = 0; a < 16; a++)
               for (int b = 0; b < 16; b++) begin
                  drive(a, b, sb[0], cb[0]);
                  judge(WN, a, b, sb[0], cb[0], 1'b1, longint'(s0), c0, o0,
                        sb[0] ? (cb[0] ? "R3 R4" : "R2 R4") : "R1 R4");
                  judge(WN, a, b, sb[0], cb[0], 1'b0, longint'(s1), c1, o1,
                        sb[0] ? "R2 R3 R4" : "R6 R4");
               end
      // R5: full-length ripple
      wide(64'hFFFF, 0, 1'b0, 1'b1, "R5");
      wide(0, 0, 1'b1, 1'b0, "R5");
      wide(0, 0, 1'b1, 1'b1, "R5 R3");
      // Wide edge values: R4 overflow without carry, both, carry only
      wide(64'h7FFF, 1, 1'b0, 1'b0, "R4");
      wide(64'h8000, 64'h8000, 1'b0, 1'b0, "R4");
      wide(64'hFFFF, 1, 1'b0, 1'b0, "R1 R4");
      wide(64'h8000, 1, 1'b1, 1'b0, "R2 R4");
      wide(64'h7FFF, 64'hFFFF, 1'b1, 1'b1, "R2 R3 R4");
      // Random wide vectors
      for (int n = 0; n < 2000; n++) begin
         longint ra, rb;
         bit rs, rc;
         ra = longint'($urandom() & 32'hFFFF);
         rb = longint'($urandom() & 32'hFFFF);
         rs = $urandom() % 2 == 1;
         rc = $urandom() % 2 == 1;
         wide(ra, rb, rs, rc, rs ? "R2 R3 R4" : "R1 R4");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule